// File: doc/BRIEF.md
# Open-Row DDR3 Command Translator

This block turns a stream of read and write requests from a simple valid/ready local port into DDR3 command-bus cycles. Each request names a rank, a bank, a row and a column. Each request produces exactly one column command (READ or WRITE). The block adds PRECHARGE and ACTIVATE cycles in front of that command when bank management needs them. A row stays open in each bank after it is used, so later accesses to the same row go straight to the column command. The one exception is a request that carries the auto-precharge flag: it closes its bank as it completes.

The request size selects the burst form. Size 2 gives a full eight-beat burst, and the next column command may follow in the very next cycle. Any other size gives an on-the-fly chopped burst of four. After a chopped burst the block leaves two empty cycles before the next column command. The row-precharge delay and the activate-to-column delay are fixed parameters (two cycles each by default). Requests are handled strictly one after another, in arrival order. Refresh, power-down, initialisation and the data path belong to neighbouring blocks.

Top module: `ddr3_cmd_xlate`

## Requirements
- R1: A request is taken on a rising edge where `req_valid` and `req_ready` are both high. The first command of its sequence appears on the command pins right after that edge. The request produces exactly one READ or WRITE command; the cycle after that command, the pins show idle unless the next request was already taken.
- R2: Command encodings (`ras_n`,`cas_n`,`we_n`) are as follows: ACTIVATE 0,1,1; PRECHARGE 0,1,0 with address bit 10 low (single bank); READ 1,0,1; WRITE 1,0,0. An issued command drives low only the `cmd_cs_n` bit of the addressed rank, and `cmd_ba` carries the bank. Idle drives every `cmd_cs_n` bit high and `ras_n`/`cas_n`/`we_n` high.
- R3: On ACTIVATE the address carries the row. On READ/WRITE the address bits are set as follows: [COL_W-1:0] hold the column; bit 10 is the auto-precharge flag; bit 12 is 1 when `req_size` is 2 (eight-beat burst) and 0 for any other size (chopped burst of four); all other bits are 0.
- R4: After a chopped column command, `req_ready` is low for that cycle and the next. It is high again on the third cycle, so two idle cycles separate it from the next column command.
- R5: After an eight-beat column command, `req_ready` stays high. A request held valid issues its column command in the very next cycle.
- R6: A request to a bank whose open row matches issues READ/WRITE immediately, with no ACTIVATE or PRECHARGE.
- R7: A request to a closed bank issues ACTIVATE, then READ/WRITE T_RCD cycles later (2 by default), with idle cycles between.
- R8: A request to a bank open on a different row issues PRECHARGE, then ACTIVATE T_RP cycles later, then READ/WRITE T_RCD cycles after the ACTIVATE.
- R9: A request with the auto-precharge flag leaves its bank closed. The next access to that bank starts with ACTIVATE, even for the same row.
- R10: `req_ready` stays low from the first command of a PRECHARGE/ACTIVATE sequence until its column command is on the pins.
- R11: Each rank/bank pair (2 x 8 by default) keeps its own open row. Opening, changing or closing one bank leaves the others unaffected.
- R12: Column commands leave in the order the requests were accepted.
- R13: After reset the command pins are idle, `req_ready` is high and every bank is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 2 = eight-beat burst, other = chopped four |
| req_autopch | input | 1 | Close the bank after this access |
| req_rank | input | RANK_W (1) | Target rank |
| req_bank | input | BANK_W (3) | Target bank within rank |
| req_row | input | ROW_W (14) | Target row |
| req_col | input | COL_W (10) | Target column |
| cmd_cs_n | output | NUM_RANKS (2) | Per-rank chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | BANK_W (3) | Bank address |
| cmd_addr | output | ROW_W (14) | Row/column address |

## Verification
The first command of a request is due one edge after acceptance. The ACTIVATE of a miss is due T_RP edges after its PRECHARGE, and the column command T_RCD edges after the ACTIVATE. After a chopped column command, `req_ready` must return on the third sample; after an eight-beat command it must stay high. The bench drives inputs and samples every output on falling edges. It counts the samples from the acceptance edge, checks every cycle of each sequence (including the idle gaps) against offsets worked out from these delays, and predicts hit, miss or closed from its own per-bank row record. A sweep covers every rank and bank with open, hit, miss and auto-precharge patterns. Further runs hold valid high across burst boundaries.

// File: rtl/ddr3x_pkg.sv
// Package: shared command kinds and column-address bit positions for the
// DDR3 command translator. Assumes a DDR3 address bus of at least 13 bits.
package ddr3x_pkg;

    // Kind of command placed on the bus in a cycle.
    typedef enum logic [2:0] {
        CK_NONE,
        CK_ACT,
        CK_PRE,
        CK_RD,
        CK_WR
    } cmd_kind_e;

    // Address bit carrying the auto-precharge flag on column commands.
    localparam int ADDR_AP_BIT = 10;
    // Address bit selecting eight-beat (1) versus chopped four (0).
    localparam int ADDR_BL_BIT = 12;

endpackage

// File: rtl/ddr3x_row_table.sv
// Open-row table: one open flag and one row per rank/bank pair.
// Looks up the addressed bank combinationally and updates from the command
// issued in the same cycle. Assumes the update index is below NBANK.
module ddr3x_row_table
    import ddr3x_pkg::*;
#(
    parameter int NBANK = 16,
    parameter int ROW_W = 14,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [ROW_W-1:0] lk_row,
    output logic             lk_open,
    output logic             lk_hit,
    input  cmd_kind_e        upd_kind,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [ROW_W-1:0] upd_row,
    input  logic             upd_ap
);

    logic             open_q [NBANK];
    logic [ROW_W-1:0] row_q  [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        // Track open state and row of bank b from the issued command.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q[b] <= 1'b0;
                row_q[b]  <= '0;
            end else if (upd_idx == IDX_W'(b)) begin
                case (upd_kind)
                    CK_ACT: begin
                        open_q[b] <= 1'b1;
                        row_q[b]  <= upd_row;
                    end
                    CK_PRE:        open_q[b] <= 1'b0;
                    CK_RD, CK_WR:  if (upd_ap) open_q[b] <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

    // Classify the addressed bank as closed, open-hit or open-miss.
    always_comb begin
        lk_open = open_q[lk_idx];
        lk_hit  = open_q[lk_idx] && (row_q[lk_idx] == lk_row);
    end

endmodule

// File: rtl/ddr3x_col_gap.sv
// Column spacing counter: after a chopped-burst column command, hold off
// the next column command for BC_WAIT cycles. Eight-beat bursts load nothing.
module ddr3x_col_gap #(
    parameter int BC_WAIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic col_fire,
    input  logic col_bc,
    output logic col_ok
);

    localparam int GAP_W = $clog2(BC_WAIT + 2);

    logic [GAP_W-1:0] gap_q;

    // Load on a chopped column command, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (col_fire && col_bc) begin
            gap_q <= GAP_W'(BC_WAIT);
        end else if (gap_q != '0) begin
            gap_q <= gap_q - 1'b1;
        end
    end

    assign col_ok = (gap_q == '0);

endmodule

// File: rtl/ddr3x_cmd_seq.sv
// Command sequencer: accepts one request at a time and decides the command
// for the current cycle (PRECHARGE, ACTIVATE or column). Misses are held in
// a pending register while the fixed T_RP / T_RCD waits run. Assumes
// T_RP >= 1 and T_RCD >= 1.
module ddr3x_cmd_seq
    import ddr3x_pkg::*;
#(
    parameter int RANK_W = 1,
    parameter int BANK_W = 3,
    parameter int IDX_W  = 4,
    parameter int ROW_W  = 14,
    parameter int COL_W  = 10,
    parameter int T_RP   = 2,
    parameter int T_RCD  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_bl8,
    input  logic              req_ap,
    input  logic [RANK_W-1:0] req_rank,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              lk_open,
    input  logic              lk_hit,
    input  logic              col_ok,
    output logic              req_ready,
    output cmd_kind_e         iss_kind,
    output logic [RANK_W-1:0] iss_rank,
    output logic [BANK_W-1:0] iss_bank,
    output logic [IDX_W-1:0]  iss_idx,
    output logic [ROW_W-1:0]  iss_row,
    output logic [COL_W-1:0]  iss_col,
    output logic              iss_ap,
    output logic              iss_bl8
);

    localparam int T_MAX = (T_RP > T_RCD) ? T_RP : T_RCD;
    localparam int CNT_W = $clog2(T_MAX + 1);

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_WAIT_RP,
        SQ_WAIT_RCD
    } sq_state_e;

    sq_state_e         state_q;
    logic [CNT_W-1:0]  wcnt_q;
    logic              p_write, p_bl8, p_ap;
    logic [RANK_W-1:0] p_rank;
    logic [BANK_W-1:0] p_bank;
    logic [IDX_W-1:0]  p_idx;
    logic [ROW_W-1:0]  p_row;
    logic [COL_W-1:0]  p_col;
    logic              accept;
    logic              use_pend;
    logic              sel_write;
    cmd_kind_e         col_kind;

    assign req_ready = (state_q == SQ_IDLE) && col_ok;
    assign accept    = req_valid && req_ready;
    assign use_pend  = (state_q != SQ_IDLE);

    // Choose the request fields for the command: pending during a sequence.
    always_comb begin
        iss_rank  = use_pend ? p_rank  : req_rank;
        iss_bank  = use_pend ? p_bank  : req_bank;
        iss_idx   = use_pend ? p_idx   : req_idx;
        iss_row   = use_pend ? p_row   : req_row;
        iss_col   = use_pend ? p_col   : req_col;
        iss_ap    = use_pend ? p_ap    : req_ap;
        iss_bl8   = use_pend ? p_bl8   : req_bl8;
        sel_write = use_pend ? p_write : req_write;
        col_kind  = sel_write ? CK_WR : CK_RD;
    end

    // Decide which command, if any, leaves in this cycle.
    always_comb begin
        iss_kind = CK_NONE;
        case (state_q)
            SQ_IDLE: begin
                if (accept) begin
                    if (lk_hit)       iss_kind = col_kind;
                    else if (lk_open) iss_kind = CK_PRE;
                    else              iss_kind = CK_ACT;
                end
            end
            SQ_WAIT_RP:  if (wcnt_q == '0) iss_kind = CK_ACT;
            SQ_WAIT_RCD: if (wcnt_q == '0) iss_kind = col_kind;
            default: ;
        endcase
    end

    // Advance the miss sequence and its wait counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            wcnt_q  <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (accept && !lk_hit) begin
                        if (lk_open) begin
                            state_q <= SQ_WAIT_RP;
                            wcnt_q  <= CNT_W'(T_RP - 1);
                        end else begin
                            state_q <= SQ_WAIT_RCD;
                            wcnt_q  <= CNT_W'(T_RCD - 1);
                        end
                    end
                end
                SQ_WAIT_RP: begin
                    if (wcnt_q == '0) begin
                        state_q <= SQ_WAIT_RCD;
                        wcnt_q  <= CNT_W'(T_RCD - 1);
                    end else begin
                        wcnt_q <= wcnt_q - 1'b1;
                    end
                end
                SQ_WAIT_RCD: begin
                    if (wcnt_q == '0) state_q <= SQ_IDLE;
                    else              wcnt_q  <= wcnt_q - 1'b1;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // Capture an accepted request that needs a PRECHARGE/ACTIVATE sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_write <= 1'b0;
            p_bl8   <= 1'b0;
            p_ap    <= 1'b0;
            p_rank  <= '0;
            p_bank  <= '0;
            p_idx   <= '0;
            p_row   <= '0;
            p_col   <= '0;
        end else if (accept && !lk_hit) begin
            p_write <= req_write;
            p_bl8   <= req_bl8;
            p_ap    <= req_ap;
            p_rank  <= req_rank;
            p_bank  <= req_bank;
            p_idx   <= req_idx;
            p_row   <= req_row;
            p_col   <= req_col;
        end
    end

endmodule

// File: rtl/ddr3x_cmd_encode.sv
// Command encoder: registers the chosen command onto the DDR3 command pins.
// Assumes ADDR_W >= 13 and COL_W <= 10 so the column bits avoid bits 10/12.
module ddr3x_cmd_encode
    import ddr3x_pkg::*;
#(
    parameter int NUM_RANKS = 2,
    parameter int RANK_W    = 1,
    parameter int BANK_W    = 3,
    parameter int ADDR_W    = 14,
    parameter int COL_W     = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  cmd_kind_e            kind,
    input  logic [RANK_W-1:0]    rank,
    input  logic [BANK_W-1:0]    bank,
    input  logic [ADDR_W-1:0]    row,
    input  logic [COL_W-1:0]     col,
    input  logic                 ap,
    input  logic                 bl8,
    output logic [NUM_RANKS-1:0] cmd_cs_n,
    output logic                 cmd_ras_n,
    output logic                 cmd_cas_n,
    output logic                 cmd_we_n,
    output logic [BANK_W-1:0]    cmd_ba,
    output logic [ADDR_W-1:0]    cmd_addr
);

    logic [NUM_RANKS-1:0] cs_sel_n;
    logic [ADDR_W-1:0]    col_addr;
    logic [2:0]           rcw_nx;
    logic                 active;

    // Decode the rank into an active-low chip-select pattern.
    always_comb begin
        for (int r = 0; r < NUM_RANKS; r++) begin
            cs_sel_n[r] = (rank != RANK_W'(r));
        end
    end

    // Assemble the column address with burst and precharge control bits.
    always_comb begin
        col_addr              = '0;
        col_addr[COL_W-1:0]   = col;
        col_addr[ADDR_AP_BIT] = ap;
        col_addr[ADDR_BL_BIT] = bl8;
    end

    // Map the command kind to the ras/cas/we levels.
    always_comb begin
        active = 1'b1;
        case (kind)
            CK_ACT:  rcw_nx = 3'b011;
            CK_PRE:  rcw_nx = 3'b010;
            CK_RD:   rcw_nx = 3'b101;
            CK_WR:   rcw_nx = 3'b100;
            default: begin
                rcw_nx = 3'b111;
                active = 1'b0;
            end
        endcase
    end

    // Register the pins; idle deselects every rank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_cs_n  <= '1;
            cmd_ras_n <= 1'b1;
            cmd_cas_n <= 1'b1;
            cmd_we_n  <= 1'b1;
            cmd_ba    <= '0;
            cmd_addr  <= '0;
        end else begin
            cmd_cs_n  <= active ? cs_sel_n : '1;
            {cmd_ras_n, cmd_cas_n, cmd_we_n} <= rcw_nx;
            cmd_ba    <= active ? bank : '0;
            case (kind)
                CK_ACT:       cmd_addr <= row;
                CK_RD, CK_WR: cmd_addr <= col_addr;
                default:      cmd_addr <= '0;
            endcase
        end
    end

endmodule

// File: rtl/ddr3_cmd_xlate.sv
// Top: local request port to DDR3 command bus with open-row bank management.
// Assumes NUM_RANKS*BANKS_PER_RANK is a power of two, ROW_W >= 13,
// COL_W <= 10, T_RP >= 1 and T_RCD >= 1.
module ddr3_cmd_xlate
    import ddr3x_pkg::*;
#(
    parameter int NUM_RANKS      = 2,
    parameter int BANKS_PER_RANK = 8,
    parameter int ROW_W          = 14,
    parameter int COL_W          = 10,
    parameter int T_RP           = 2,
    parameter int T_RCD          = 2,
    parameter int BC_WAIT        = 2,
    localparam int RANK_W = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
    localparam int BANK_W = $clog2(BANKS_PER_RANK)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [1:0]           req_size,
    input  logic                 req_autopch,
    input  logic [RANK_W-1:0]    req_rank,
    input  logic [BANK_W-1:0]    req_bank,
    input  logic [ROW_W-1:0]     req_row,
    input  logic [COL_W-1:0]     req_col,
    output logic [NUM_RANKS-1:0] cmd_cs_n,
    output logic                 cmd_ras_n,
    output logic                 cmd_cas_n,
    output logic                 cmd_we_n,
    output logic [BANK_W-1:0]    cmd_ba,
    output logic [ROW_W-1:0]     cmd_addr
);

    localparam int NBANK = NUM_RANKS * BANKS_PER_RANK;
    localparam int IDX_W = $clog2(NBANK);

    logic [IDX_W-1:0]  req_idx;
    logic              req_bl8;
    logic              lk_open, lk_hit, col_ok;
    cmd_kind_e         iss_kind;
    logic [RANK_W-1:0] iss_rank;
    logic [BANK_W-1:0] iss_bank;
    logic [IDX_W-1:0]  iss_idx;
    logic [ROW_W-1:0]  iss_row;
    logic [COL_W-1:0]  iss_col;
    logic              iss_ap, iss_bl8, iss_col_fire;

    assign req_idx      = IDX_W'(req_rank) * IDX_W'(BANKS_PER_RANK) + IDX_W'(req_bank);
    assign req_bl8      = (req_size == 2'd2);
    assign iss_col_fire = (iss_kind == CK_RD) || (iss_kind == CK_WR);

    ddr3x_row_table #(
        .NBANK (NBANK),
        .ROW_W (ROW_W),
        .IDX_W (IDX_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_idx   (req_idx),
        .lk_row   (req_row),
        .lk_open  (lk_open),
        .lk_hit   (lk_hit),
        .upd_kind (iss_kind),
        .upd_idx  (iss_idx),
        .upd_row  (iss_row),
        .upd_ap   (iss_ap)
    );

    ddr3x_col_gap #(
        .BC_WAIT (BC_WAIT)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .col_fire (iss_col_fire),
        .col_bc   (!iss_bl8),
        .col_ok   (col_ok)
    );

    ddr3x_cmd_seq #(
        .RANK_W (RANK_W),
        .BANK_W (BANK_W),
        .IDX_W  (IDX_W),
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .T_RP   (T_RP),
        .T_RCD  (T_RCD)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_bl8   (req_bl8),
        .req_ap    (req_autopch),
        .req_rank  (req_rank),
        .req_bank  (req_bank),
        .req_idx   (req_idx),
        .req_row   (req_row),
        .req_col   (req_col),
        .lk_open   (lk_open),
        .lk_hit    (lk_hit),
        .col_ok    (col_ok),
        .req_ready (req_ready),
        .iss_kind  (iss_kind),
        .iss_rank  (iss_rank),
        .iss_bank  (iss_bank),
        .iss_idx   (iss_idx),
        .iss_row   (iss_row),
        .iss_col   (iss_col),
        .iss_ap    (iss_ap),
        .iss_bl8   (iss_bl8)
    );

    ddr3x_cmd_encode #(
        .NUM_RANKS (NUM_RANKS),
        .RANK_W    (RANK_W),
        .BANK_W    (BANK_W),
        .ADDR_W    (ROW_W),
        .COL_W     (COL_W)
    ) u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (iss_kind),
        .rank      (iss_rank),
        .bank      (iss_bank),
        .row       (iss_row),
        .col       (iss_col),
        .ap        (iss_ap),
        .bl8       (iss_bl8),
        .cmd_cs_n  (cmd_cs_n),
        .cmd_ras_n (cmd_ras_n),
        .cmd_cas_n (cmd_cas_n),
        .cmd_we_n  (cmd_we_n),
        .cmd_ba    (cmd_ba),
        .cmd_addr  (cmd_addr)
    );

endmodule

// File: rtl/ddr3x_xlate_chk.sv
// Checker for the command translator: watches the request handshake and the
// command pins only. A cycle counter since reset keeps $past inside the
// cycles that follow reset.
module ddr3x_xlate_chk #(
    parameter int NUM_RANKS = 2,
    parameter int T_RP      = 2,
    parameter int T_RCD     = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic [NUM_RANKS-1:0] cmd_cs_n,
    input logic                 cmd_ras_n,
    input logic                 cmd_cas_n,
    input logic                 cmd_we_n,
    input logic                 ap_bit,
    input logic                 bl_bit
);

    logic [1:0] since_q;
    logic       any_cs, is_act, is_pre, is_col;

    // Count cycles since reset release, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)                since_q <= 2'd0;
        else if (since_q != 2'd3)  since_q <= since_q + 2'd1;
    end

    assign any_cs = (cmd_cs_n != '1);
    assign is_act = any_cs && !cmd_ras_n &&  cmd_cas_n &&  cmd_we_n;
    assign is_pre = any_cs && !cmd_ras_n &&  cmd_cas_n && !cmd_we_n;
    assign is_col = any_cs &&  cmd_ras_n && !cmd_cas_n;

    a_r1_cmd_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q >= 2'd1 && $past(req_valid && req_ready)) |-> any_cs);

    a_r2_one_rank: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cmd_cs_n));

    a_r2_pre_single_bank: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> !ap_bit);

    a_r4_bc_gap_first: assert property (@(posedge clk) disable iff (!rst_n)
        (is_col && !bl_bit) |=> !is_col);

    a_r4_bc_gap_second: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q >= 2'd2 && $past(is_col && !bl_bit, 2)) |-> !is_col);

    a_r4_bc_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (is_col && !bl_bit) |-> !req_ready);

    a_r10_seq_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pre || is_act) |-> !req_ready);

    a_r13_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q == 2'd0) |-> (!any_cs && cmd_ras_n && cmd_cas_n && cmd_we_n && req_ready));

    if (T_RCD > 1) begin : g_rcd
        a_r7_act_then_wait: assert property (@(posedge clk) disable iff (!rst_n)
            is_act |=> !is_col);
    end

    if (T_RP > 1) begin : g_rp
        a_r8_pre_then_wait: assert property (@(posedge clk) disable iff (!rst_n)
            is_pre |=> (!is_act && !is_col));
    end

endmodule

bind ddr3_cmd_xlate ddr3x_xlate_chk #(
    .NUM_RANKS (NUM_RANKS),
    .T_RP      (T_RP),
    .T_RCD     (T_RCD)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .cmd_cs_n  (cmd_cs_n),
    .cmd_ras_n (cmd_ras_n),
    .cmd_cas_n (cmd_cas_n),
    .cmd_we_n  (cmd_we_n),
    .ap_bit    (cmd_addr[10]),
    .bl_bit    (cmd_addr[12])
);

// File: tb/ddr3_cmd_xlate_tb.sv
`timescale 1ns/1ps
// Bench: sweeps every rank/bank through closed, hit, miss and auto-precharge
// cases, then held-valid runs, checking every cycle at falling edges.
module ddr3_cmd_xlate_tb;

    localparam int NB = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd1;
    logic        req_autopch = 1'b0;
    logic        req_rank = 1'b0;
    logic [2:0]  req_bank = 3'd0;
    logic [13:0] req_row = '0;
    logic [9:0]  req_col = '0;
    logic [1:0]  cmd_cs_n;
    logic        cmd_ras_n, cmd_cas_n, cmd_we_n;
    logic [2:0]  cmd_ba;
    logic [13:0] cmd_addr;

    int          n_chk = 0;
    int          n_err = 0;
    bit          m_open [NB];
    logic [13:0] m_row  [NB];

    always #2 clk = ~clk;

    ddr3_cmd_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_size(req_size), .req_autopch(req_autopch),
        .req_rank(req_rank), .req_bank(req_bank), .req_row(req_row),
        .req_col(req_col), .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n),
        .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n), .cmd_ba(cmd_ba),
        .cmd_addr(cmd_addr)
    );

    // 0 idle, 1 ACT, 2 PRE, 3 RD, 4 WR, 5 illegal
    function automatic int decode();
        if (cmd_cs_n == 2'b11) return (cmd_ras_n && cmd_cas_n && cmd_we_n) ? 0 : 5;
        case ({cmd_ras_n, cmd_cas_n, cmd_we_n})
            3'b011:  return 1;
            3'b010:  return 2;
            3'b101:  return 3;
            3'b100:  return 4;
            default: return 5;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input string what);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    task automatic expect_cmd(input int kind, input int rank, input int bank,
                              input logic [13:0] addr, input logic [13:0] mask,
                              input string tag);
        int got;
        got = decode();
        chk(got == kind, tag, $sformatf("command kind got %0d exp %0d", got, kind));
        if (kind != 0) begin
            chk(cmd_cs_n == ~(2'b01 << rank), "R2",
                $sformatf("cs_n got %b exp %b", cmd_cs_n, ~(2'b01 << rank)));
            chk(cmd_ba == 3'(bank), "R2", $sformatf("ba got %0d exp %0d", cmd_ba, bank));
            chk((cmd_addr & mask) == (addr & mask), "R3",
                $sformatf("addr got %h exp %h (mask %h)", cmd_addr & mask, addr & mask, mask));
        end
    endtask

    task automatic expect_ready(input bit exp, input string tag);
        chk(req_ready == exp, tag, $sformatf("ready got %0b exp %0b", req_ready, exp));
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 50 && !req_ready; i++) @(negedge clk);
    endtask

    // One request, checked cycle by cycle from the acceptance edge.
    task automatic run_req(input int r, input int b, input logic [13:0] row,
                           input logic [9:0] col, input bit wr,
                           input logic [1:0] size, input bit ap);
        int idx, path, ck;
        logic [13:0] ea;
        bit bl8;
        idx  = r * 8 + b;
        path = !m_open[idx] ? 1 : (m_row[idx] == row ? 0 : 2); // 0 hit,1 closed,2 miss
        bl8  = (size == 2'd2);
        ea   = '0;
        ea[9:0] = col;
        ea[10]  = ap;
        ea[12]  = bl8;
        ck = wr ? 4 : 3;
        wait_ready();
        req_valid = 1'b1; req_rank = 1'(r); req_bank = 3'(b); req_row = row;
        req_col = col; req_write = wr; req_size = size; req_autopch = ap;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (path == 2) begin
            expect_cmd(2, r, b, 14'h0000, 14'h0400, "R8");
            expect_ready(1'b0, "R10");
            @(negedge clk); expect_cmd(0, 0, 0, '0, '0, "R8"); expect_ready(1'b0, "R10");
            @(negedge clk); expect_cmd(1, r, b, row, 14'h3fff, "R8"); expect_ready(1'b0, "R10");
            @(negedge clk); expect_cmd(0, 0, 0, '0, '0, "R8"); expect_ready(1'b0, "R10");
            @(negedge clk);
        end else if (path == 1) begin
            expect_cmd(1, r, b, row, 14'h3fff, "R7");
            expect_ready(1'b0, "R10");
            @(negedge clk); expect_cmd(0, 0, 0, '0, '0, "R7"); expect_ready(1'b0, "R10");
            @(negedge clk);
        end
        expect_cmd(ck, r, b, ea, 14'h3fff, path == 0 ? "R6" : "R1");
        if (bl8) begin
            expect_ready(1'b1, "R5");
            @(negedge clk); expect_cmd(0, 0, 0, '0, '0, "R1");
        end else begin
            expect_ready(1'b0, "R4");
            @(negedge clk); expect_cmd(0, 0, 0, '0, '0, "R1"); expect_ready(1'b0, "R4");
            @(negedge clk); expect_cmd(0, 0, 0, '0, '0, "R4"); expect_ready(1'b1, "R4");
        end
        if (path != 0) begin
            m_open[idx] = 1'b1;
            m_row[idx]  = row;
        end
        if (ap) m_open[idx] = 1'b0;
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: run did not finish, got hang exp completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < NB; i++) begin
            m_open[i] = 1'b0;
            m_row[i]  = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13: idle pins and ready after reset
        expect_cmd(0, 0, 0, '0, '0, "R13");
        expect_ready(1'b1, "R13");

        // R13/R7/R11: every bank starts closed, open each with its own row
        for (int r = 0; r < 2; r++)
            for (int b = 0; b < 8; b++)
                run_req(r, b, 14'(r * 8 + b + 3), 10'(b * 5 + r), b[0], (b % 2) ? 2'd2 : 2'd1, 1'b0);
        // R6/R11: all hits on their own rows
        for (int r = 0; r < 2; r++)
            for (int b = 0; b < 8; b++)
                run_req(r, b, 14'(r * 8 + b + 3), 10'(1000 - b), !b[0], (b % 3 == 0) ? 2'd3 : 2'd2, 1'b0);
        // R8/R9: misses, half with auto-precharge
        for (int r = 0; r < 2; r++)
            for (int b = 0; b < 8; b++)
                run_req(r, b, 14'(r * 8 + b + 100), 10'(b * 7), b[0], 2'd1, b[1]);
        // R9/R11: same rows again; auto-precharged banks reopen, others hit
        for (int r = 0; r < 2; r++)
            for (int b = 0; b < 8; b++)
                run_req(r, b, 14'(r * 8 + b + 100), 10'(b + 512), 1'b0, 2'd2, 1'b0);

        // R5/R12: two eight-beat hits with valid held, back to back in order
        wait_ready();
        req_valid = 1'b1; req_rank = 1'b0; req_bank = 3'd0; req_row = 14'd100;
        req_col = 10'd11; req_write = 1'b0; req_size = 2'd2; req_autopch = 1'b0;
        @(posedge clk);
        @(negedge clk);
        expect_cmd(3, 0, 0, 14'h100b, 14'h3fff, "R12");
        expect_ready(1'b1, "R5");
        req_col = 10'd22; req_write = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        expect_cmd(4, 0, 0, 14'h1016, 14'h3fff, "R5");

        // R4/R12: chopped hit then a held request waits two idle cycles
        wait_ready();
        req_valid = 1'b1; req_rank = 1'b1; req_bank = 3'd7; req_row = 14'd115;
        req_col = 10'd33; req_write = 1'b1; req_size = 2'd1;
        @(posedge clk);
        @(negedge clk);
        expect_cmd(4, 1, 7, 14'h0021, 14'h3fff, "R4");
        req_col = 10'd44; req_write = 1'b0; req_size = 2'd2;
        @(negedge clk); expect_cmd(0, 0, 0, '0, '0, "R4");
        @(negedge clk); expect_cmd(0, 0, 0, '0, '0, "R4");
        @(negedge clk);
        req_valid = 1'b0;
        expect_cmd(3, 1, 7, 14'h102c, 14'h3fff, "R12");

        // R9: auto-precharge on a hit closes the bank for the same row
        run_req(0, 3, 14'd103, 10'd5, 1'b1, 2'd2, 1'b1);
        run_req(0, 3, 14'd103, 10'd6, 1'b0, 2'd2, 1'b0);

        @(negedge clk);
        expect_ready(1'b1, "R5");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule